// File: doc/BRIEF.md
# Wavefront Fetch Eligibility Arbiter

This block decides which wavefront slot may issue its next instruction fetch. For each of `SLOTS` slots it keeps two flags: one saying the slot is waiting in the ready queue, and one saying a fetch is outstanding. Every cycle it examines each slot that is not already waiting. A slot joins the queue when four things hold:

- the wavefront is running;
- its instruction buffer holds no more than `OCC_LIMIT` entries;
- the buffer holds no branch;
- no fetch for it is outstanding.

Once a slot is waiting, the block does not look at it again until it has been granted.

The queue hands out slots in order of arrival. Slots that arrive in the same cycle are ordered by ascending slot index. The head of the queue is offered on a valid/ready output stream. A grant happens when `fetch_valid` and `fetch_ready` are both high. On a grant the slot leaves the queue, its waiting flag clears and its outstanding-fetch flag sets. The flag clears again when the memory side reports a fetch return for that slot. The slot may then requalify.

The output stream obeys the usual back-pressure rules. While `fetch_valid` is high and `fetch_ready` is low, the offered slot stays unchanged and nothing is granted. `fetch_valid` never depends on `fetch_ready`. At most one slot is granted per cycle.

Top module: `wave_fetch_arb`

## Requirements
- R1: After reset, `fetch_valid` is low, the queue is empty and `pend_flags` is all zero.
- R2: A slot joins the queue only when its running bit is 1, its occupancy field (unsigned, slot i at bits [i*OCC_W +: OCC_W] of `slot_occ`) is at most OCC_LIMIT (4 by default), its branch bit is 0 and its pending flag is 0. A slot that qualifies in cycle t is offered on `fetch_slot` from cycle t+1 when it is the oldest entry.
- R3: A waiting slot is not re-evaluated. A change of its running, occupancy or branch inputs after it joined neither removes it nor queues it twice, and it is still granted.
- R4: Grants follow arrival order (oldest first). Slots arriving in the same cycle are granted lowest index first.
- R5: `fetch_valid` is low whenever the queue is empty, and no grant happens then.
- R6: On a grant, in the following cycle the granted slot's bit in `pend_flags` is 1, the slot is no longer in the queue, and at most one slot is granted per cycle.
- R7: While `fetch_valid` is high and `fetch_ready` is low, `fetch_valid` stays high, `fetch_slot` is unchanged and no pending flag is set.
- R8: A cycle with `ret_valid` high clears the pending flag of slot `ret_slot` on the next edge, after which the slot may requalify. A return naming a slot whose flag is 0 leaves `pend_flags` unchanged. If a grant and a return hit the same slot in one cycle, the flag is set.
- R9: `fetch_onehot` has exactly bit `fetch_slot` set while `fetch_valid` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_running | input | SLOTS | Per-slot running status |
| slot_occ | input | SLOTS*OCC_W | Per-slot instruction-buffer occupancy, slot i in bits [i*OCC_W +: OCC_W] |
| slot_branch | input | SLOTS | Per-slot flag: buffer holds a branch |
| ret_valid | input | 1 | Fetch return strobe |
| ret_slot | input | ID_W | Slot whose fetch returned |
| fetch_valid | output | 1 | A slot is offered for fetch |
| fetch_ready | input | 1 | Consumer accepts the offered slot |
| fetch_slot | output | ID_W | Index of the offered slot |
| fetch_onehot | output | SLOTS | One-hot form of the offered slot |
| pend_flags | output | SLOTS | Per-slot outstanding-fetch flags |

## Verification
The assertions assume the following about the inputs:

- `ret_slot` names an existing slot whenever `ret_valid` is high.
- The slot set never exceeds the queue depth. This follows from the rule that a slot can wait only once, so the no-overflow check covers that invariant rather than an input condition.

The stimulus drives every input away from the clock edge. Returns are aimed mostly at slots the reference model shows as pending, with a share sent to idle or waiting slots so the ignored-return rule is exercised. Occupancy values straddle the limit, and `fetch_ready` toggles randomly so that stalls and grants interleave with arrivals.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  // Default occupancy at or below which a slot may request more instructions
  localparam int unsigned DEF_OCC_LIMIT = 4;

  function automatic int unsigned id_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wfa_elig.sv
module wfa_elig #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned OCC_W     = 4,
  parameter int unsigned OCC_LIMIT = 4
) (
  input  logic [SLOTS-1:0]       running,
  input  logic [SLOTS*OCC_W-1:0] occ,
  input  logic [SLOTS-1:0]       branch,
  input  logic [SLOTS-1:0]       pending,
  input  logic [SLOTS-1:0]       queued,
  output logic [SLOTS-1:0]       join_vec
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [OCC_W-1:0] level;
    logic             low_fill;
    assign level    = occ[g*OCC_W +: OCC_W];
    assign low_fill = (int'(level) <= int'(OCC_LIMIT));
    assign join_vec[g] = running[g] & low_fill & ~branch[g] & ~pending[g] & ~queued[g];
  end
endmodule

// File: rtl/wfa_order_fifo.sv
module wfa_order_fifo #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned ID_W  = wfa_pkg::id_width(SLOTS),
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SLOTS-1:0] push_vec,
  input  logic            pop,
  output logic [ID_W-1:0] head_id,
  output logic            not_empty
);
  logic [ID_W-1:0]  mem [SLOTS];
  logic [ID_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] rank [SLOTS];
  logic [CNT_W-1:0] n_push;

  function automatic logic [ID_W-1:0] wrap(input logic [ID_W-1:0] base,
                                           input logic [CNT_W-1:0] off);
    int s;
    s = int'(base) + int'(off);
    if (s >= int'(SLOTS)) s = s - int'(SLOTS);
    return ID_W'(s);
  endfunction

  // Lower slot indices take earlier positions among same-cycle arrivals
  always_comb begin
    n_push = '0;
    for (int i = 0; i < SLOTS; i++) begin
      rank[i] = n_push;
      n_push  = n_push + CNT_W'(push_vec[i]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (push_vec[i]) mem[wrap(wr_ptr, rank[i])] <= ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wrap(wr_ptr, n_push);
      if (pop) rd_ptr <= wrap(rd_ptr, CNT_W'(1));
      count <= count + n_push - CNT_W'(pop);
    end
  end

  assign head_id   = mem[rd_ptr];
  assign not_empty = (count != '0);

  // R5
  pop_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(n_push) - int'(pop)) <= int'(SLOTS));
endmodule

// File: rtl/wfa_slot_flags.sv
module wfa_slot_flags #(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned ID_W = wfa_pkg::id_width(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] join_vec,
  input  logic             grant,
  input  logic [ID_W-1:0]  grant_id,
  input  logic             ret_valid,
  input  logic [ID_W-1:0]  ret_id,
  output logic [SLOTS-1:0] queued,
  output logic [SLOTS-1:0] pending
);
  logic [SLOTS-1:0] grant_mask, ret_mask;

  always_comb begin
    grant_mask = '0;
    ret_mask   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      grant_mask[i] = grant && (grant_id == ID_W'(i));
      ret_mask[i]   = ret_valid && (ret_id == ID_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queued  <= '0;
      pending <= '0;
    end else begin
      queued  <= (queued | join_vec) & ~grant_mask;
      pending <= (pending & ~ret_mask) | grant_mask;
    end
  end

  // R6
  queued_pending_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (queued & pending) == '0);

  // R6
  grant_marks_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> pending[$past(grant_id)] && !queued[$past(grant_id)]);

  // R3
  no_double_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_vec & queued) == '0);
endmodule

// File: rtl/wave_fetch_arb.sv
module wave_fetch_arb #(
  parameter int unsigned SLOTS     = 8,
  parameter int unsigned OCC_W     = 4,
  parameter int unsigned OCC_LIMIT = wfa_pkg::DEF_OCC_LIMIT,
  localparam int unsigned ID_W     = wfa_pkg::id_width(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOTS-1:0]       slot_running,
  input  logic [SLOTS*OCC_W-1:0] slot_occ,
  input  logic [SLOTS-1:0]       slot_branch,
  input  logic                   ret_valid,
  input  logic [ID_W-1:0]        ret_slot,
  output logic                   fetch_valid,
  input  logic                   fetch_ready,
  output logic [ID_W-1:0]        fetch_slot,
  output logic [SLOTS-1:0]       fetch_onehot,
  output logic [SLOTS-1:0]       pend_flags
);
  logic [SLOTS-1:0] join_vec, queued, pending;
  logic             grant, not_empty;
  logic [ID_W-1:0]  head_id;

  wfa_elig #(.SLOTS(SLOTS), .OCC_W(OCC_W), .OCC_LIMIT(OCC_LIMIT)) u_elig (
    .running(slot_running), .occ(slot_occ), .branch(slot_branch),
    .pending(pending), .queued(queued), .join_vec(join_vec));

  wfa_order_fifo #(.SLOTS(SLOTS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_vec(join_vec), .pop(grant),
    .head_id(head_id), .not_empty(not_empty));

  wfa_slot_flags #(.SLOTS(SLOTS)) u_flags (
    .clk(clk), .rst_n(rst_n), .join_vec(join_vec), .grant(grant),
    .grant_id(head_id), .ret_valid(ret_valid), .ret_id(ret_slot),
    .queued(queued), .pending(pending));

  assign fetch_valid = not_empty;
  assign fetch_slot  = head_id;
  assign grant       = not_empty & fetch_ready;
  assign pend_flags  = pending;

  always_comb begin
    fetch_onehot = '0;
    if (not_empty) fetch_onehot[head_id] = 1'b1;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_slot));

  // R7
  stall_no_new_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> (pend_flags & ~$past(pend_flags)) == '0);

  // R9
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fetch_onehot) && (fetch_valid == (fetch_onehot != '0)));

  // R8
  return_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !(grant && head_id == ret_slot) |=> !pend_flags[$past(ret_slot)]);
endmodule

// File: tb/sim_wave_fetch_arb.sv
module sim_wave_fetch_arb;
  localparam int N = 8;
  localparam int OW = 4;
  localparam int LIM = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] run, br;
  logic [N*OW-1:0] occ;
  logic ret_valid, ready;
  logic [IW-1:0] ret_slot;
  logic fetch_valid;
  logic [IW-1:0] fetch_slot;
  logic [N-1:0] fetch_onehot, pend_flags;

  int checks = 0;
  int fails = 0;
  int q[$];
  bit mq[N];
  bit mp[N];

  always #5 clk = ~clk;

  wave_fetch_arb #(.SLOTS(N), .OCC_W(OW), .OCC_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_running(run), .slot_occ(occ),
    .slot_branch(br), .ret_valid(ret_valid), .ret_slot(ret_slot),
    .fetch_valid(fetch_valid), .fetch_ready(ready), .fetch_slot(fetch_slot),
    .fetch_onehot(fetch_onehot), .pend_flags(pend_flags));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_slot(input int i, input bit r, input int o, input bit b);
    run[i] = r;
    occ[i*OW +: OW] = OW'(o);
    br[i] = b;
  endtask

  function automatic int model_pend();
    int v = 0;
    for (int i = 0; i < N; i++) if (mp[i]) v |= (1 << i);
    return v;
  endfunction

  // Compare outputs against the model, advance the model, cross one edge
  task automatic step();
    int s = -1;
    bit elig[N];
    chk("R5", int'(fetch_valid), int'(q.size() > 0));
    if (q.size() > 0) begin
      chk("R4", int'(fetch_slot), q[0]);
      chk("R9", int'(fetch_onehot), 1 << q[0]);
    end else chk("R9", int'(fetch_onehot), 0);
    chk("R6/R8", int'(pend_flags), model_pend());
    for (int i = 0; i < N; i++)
      elig[i] = run[i] && (int'(occ[i*OW +: OW]) <= LIM) && !br[i] && !mq[i] && !mp[i];
    if (q.size() > 0 && ready) s = q.pop_front();
    if (ret_valid) mp[ret_slot] = 1'b0;
    if (s >= 0) begin mp[s] = 1'b1; mq[s] = 1'b0; end
    for (int i = 0; i < N; i++) if (elig[i]) begin q.push_back(i); mq[i] = 1'b1; end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = '0; br = '0; occ = '0;
    ret_valid = 1'b0; ret_slot = '0; ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(fetch_valid), 0);
    chk("R1", int'(pend_flags), 0);
    rst_n = 1'b1;

    // R2: only slot 3 qualifies (5 is over the limit, 6 holds a branch)
    set_slot(3, 1, 4, 0); set_slot(5, 1, 5, 0); set_slot(6, 1, 0, 1);
    step();
    chk("R2", int'(fetch_valid), 1);
    chk("R2", int'(fetch_slot), 3);
    // R7: stalled offer holds
    step(); step();
    chk("R7", int'(fetch_slot), 3);
    chk("R7", int'(pend_flags), 0);

    // R3: slot 3 stops running while waiting, still offered
    set_slot(3, 0, 9, 1); set_slot(1, 1, 0, 0);
    step();
    chk("R3", int'(fetch_slot), 3);
    step();
    set_slot(1, 0, 0, 0);
    ready = 1'b1;
    step();
    chk("R6", int'(pend_flags), 'h08);
    chk("R3", int'(fetch_slot), 1);
    ready = 1'b0;

    // R4: same-cycle arrivals behind slot 1
    set_slot(0, 1, 2, 0); set_slot(2, 1, 2, 0); set_slot(7, 1, 2, 0);
    step();
    set_slot(0, 0, 0, 0); set_slot(2, 0, 0, 0); set_slot(7, 0, 0, 0);
    ready = 1'b1;
    foreach (q[k]) ;
    chk("R4", int'(fetch_slot), 1); step();
    chk("R4", int'(fetch_slot), 0); step();
    chk("R4", int'(fetch_slot), 2); step();
    chk("R4", int'(fetch_slot), 7); step();
    chk("R5", int'(fetch_valid), 0);
    chk("R6", int'(pend_flags), 'h8F);

    // R8: return to an idle slot is ignored, a real return clears
    ret_valid = 1'b1; ret_slot = 3'd4;
    step();
    chk("R8", int'(pend_flags), 'h8F);
    ret_slot = 3'd3;
    step();
    ret_valid = 1'b0;
    chk("R8", int'(pend_flags), 'h87);
    set_slot(3, 1, 0, 0);
    step();
    chk("R8", int'(fetch_slot), 3);
    set_slot(3, 0, 0, 0);
    step(); step();

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++)
        set_slot(i, ($urandom_range(0, 3) != 0), $urandom_range(0, 6), ($urandom_range(0, 4) == 0));
      ready = ($urandom_range(0, 2) != 0);
      ret_valid = ($urandom_range(0, 1) == 1);
      ret_slot = IW'($urandom_range(0, N - 1));
      if ($urandom_range(0, 4) != 0)
        for (int i = 0; i < N; i++) if (mp[i] && $urandom_range(0, 1) == 1) ret_slot = IW'(i);
      step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule